// File: doc/BRIEF.md
# Pipelined 64-bit Integer Multiply Unit

This unit is the multiply slot of a 64-bit processor's execution stage. Each cycle it can take one beat made of a valid flag, a 2-bit operation code, a 5-bit destination register number, a record flag and two 65-bit operands. The issuing stage has already widened each operand by one bit: bit 64 repeats bit 63 for a signed operation and is zero for an unsigned one. For the 32-bit forms the operand is widened from bit 31 instead. A single signed multiply of the two 65-bit values serves every form. The operation code then picks which slice of the product is written back.

After a fixed number of clocks the unit presents a writeback beat. That beat holds a register-write enable, the destination number and a 64-bit result. When the record flag was set it also holds a 32-bit condition word, which tells whether the result is negative, positive or zero. Beats never stall and never pass one another. An asynchronous active-low reset empties the pipe, and its release is synchronised inside the unit.

Top module: `mul_pipe_unit`

## Requirements
- R1: A beat sampled with `in_valid` high on a rising edge appears with `out_valid` high exactly `DEPTH` rising edges later. `DEPTH` defaults to 4 and must be at least 2.
- R2: `out_valid` is low on every cycle that has no matching input beat. A new beat may enter on every cycle. Back-to-back beats leave in the order they entered, one output cycle per input cycle.
- R3: While `rst_n` is low, `out_valid`, `out_rd_we` and `out_cr_we` are low from the next rising edge onward. Beats in flight when reset is asserted never appear. Release takes effect after two rising edges.
- R4: Operation code 0 (low doubleword) returns product bits 63:0. For example, 0x1000 times 0x1111 gives 0x1111000. Code 3 behaves exactly like code 0.
- R5: Operation code 1 (high doubleword) with sign-widened operands returns bits 127:64 of the signed 128-bit product.
- R6: Operation code 1 with zero-widened operands returns bits 127:64 of the unsigned 128-bit product.
- R7: Operation code 2 (high word) takes operands widened from bit 31 and returns bits 63:32 of the 64-bit product in `out_data[31:0]`. It returns the same 32 bits again in `out_data[63:32]`.
- R8: `out_rd` carries the `in_rd` of its own beat. `out_rd_we` is high exactly when `out_valid` is high.
- R9: `out_cr_we` is high only on a valid output whose beat had `in_rec` set. It stays low when `in_rec` was clear.
- R10: The condition word is 0x80000000 when result bit 63 is set, 0x20000000 when the result is zero, and 0x40000000 otherwise. Bit 28 and all lower bits are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| in_valid | input | 1 | Input beat present this cycle |
| in_op | input | 2 | 0 low doubleword, 1 high doubleword, 2 high word, 3 same as 0 |
| in_rd | input | 5 | Destination register number |
| in_rec | input | 1 | Request a condition word for this beat |
| in_a | input | XLEN+1 | First operand, already widened by the issuer |
| in_b | input | XLEN+1 | Second operand, already widened by the issuer |
| out_valid | output | 1 | Writeback beat present |
| out_rd_we | output | 1 | Register write enable |
| out_rd | output | 5 | Destination register number of the beat |
| out_data | output | XLEN | Selected product slice |
| out_cr_we | output | 1 | Condition word write enable |
| out_cr | output | 32 | Condition word |

## Verification
The bench drives runs of back-to-back beats with random gaps. A unit that lost beats, doubled them or used the wrong latency would fail the valid comparison made on every cycle. The high-doubleword code is driven with both sign-widened and zero-widened operands, so a unit that treated the operands as unsigned, or dropped the extension bit, would return a wrong high half. The condition word is checked with results that are zero, negative (an all-ones high half) and positive; a priority mistake between the sign test and the zero test would show up here. A reset issued while beats are still in the pipe must keep those beats from ever appearing; a unit that left any stage valid bit set would emit a stale beat after reset is released.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

  localparam int REGW = 5;
  localparam int CRW  = 32;

  // operation code carried down the pipe
  typedef enum logic [1:0] {
    MOP_LO64 = 2'd0,
    MOP_HI64 = 2'd1,
    MOP_HI32 = 2'd2,
    MOP_RSVD = 2'd3
  } mop_e;

  // control fields that travel beside the data
  typedef struct packed {
    logic            rec;
    logic [REGW-1:0] rd;
    mop_e            op;
  } mctl_t;

  localparam logic [CRW-1:0] CR_NEG  = 32'h8000_0000;
  localparam logic [CRW-1:0] CR_POS  = 32'h4000_0000;
  localparam logic [CRW-1:0] CR_ZERO = 32'h2000_0000;

endpackage

// File: rtl/mulp_rst_sync.sv
module mulp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/mulp_ctl_pipe.sv
module mulp_ctl_pipe
  import mulp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  mctl_t                 in_ctl,
  output logic [DEPTH-1:0]      vld_q,
  output mctl_t [DEPTH-1:0]     ctl_q
);

  logic [DEPTH-1:0]  vld_d;
  mctl_t [DEPTH-1:0] ctl_d;
  logic [DEPTH-1:0]  ctl_en;

  // next state: valid bits shift every cycle, control loads only with a beat
  always_comb begin
    vld_d     = {vld_q[DEPTH-2:0], in_valid};
    ctl_d[0]  = in_ctl;
    ctl_en[0] = in_valid;
    for (int k = 1; k < DEPTH; k++) begin
      ctl_d[k]  = ctl_q[k-1];
      ctl_en[k] = vld_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (ctl_en[k]) begin
        ctl_q[k] <= ctl_d[k];
      end
    end
  end

endmodule

// File: rtl/mulp_core.sv
module mulp_core #(
  parameter int XLEN  = 64,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                in_valid,
  input  logic [XLEN:0]       in_a,
  input  logic [XLEN:0]       in_b,
  input  logic [DEPTH-2:0]    stg_vld,
  output logic [2*XLEN-1:0]   prod
);

  localparam int OPW = XLEN + 1;
  localparam int PW  = 2 * XLEN;

  logic [XLEN:0] a_q;
  logic [XLEN:0] b_q;

  logic signed [PW-1:0] ax;
  logic signed [PW-1:0] bx;

  logic [DEPTH-1:1][PW-1:0] p_d;
  logic [DEPTH-1:1][PW-1:0] p_q;
  logic [DEPTH-1:1]         p_en;

  // operand capture stage
  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_q <= in_a;
      b_q <= in_b;
    end
  end

  // one signed multiply; the low 128 bits of a 65x65 product are exact
  always_comb begin
    ax      = $signed({{(PW-OPW){a_q[XLEN]}}, a_q});
    bx      = $signed({{(PW-OPW){b_q[XLEN]}}, b_q});
    p_d[1]  = ax * bx;
    p_en[1] = stg_vld[0];
    for (int k = 2; k < DEPTH; k++) begin
      p_d[k]  = p_q[k-1];
      p_en[k] = stg_vld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 1; k < DEPTH; k++) begin
      if (p_en[k]) begin
        p_q[k] <= p_d[k];
      end
    end
  end

  assign prod = p_q[DEPTH-1];

endmodule

// File: rtl/mulp_fmt.sv
module mulp_fmt
  import mulp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] prod,
  input  mop_e              op,
  output logic [XLEN-1:0]   res,
  output logic [CRW-1:0]    cr
);

  localparam int HW = XLEN / 2;

  always_comb begin
    unique case (op)
      MOP_HI64: res = prod[2*XLEN-1:XLEN];
      MOP_HI32: res = {prod[XLEN-1:HW], prod[XLEN-1:HW]};
      default:  res = prod[XLEN-1:0];
    endcase
  end

  // sign test has priority over the zero test
  always_comb begin
    if (res[XLEN-1]) begin
      cr = CR_NEG;
    end else if (res == '0) begin
      cr = CR_ZERO;
    end else begin
      cr = CR_POS;
    end
  end

endmodule

// File: rtl/mul_pipe_unit.sv
module mul_pipe_unit
  import mulp_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int XLEN  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [REGW-1:0] in_rd,
  input  logic            in_rec,
  input  logic [XLEN:0]   in_a,
  input  logic [XLEN:0]   in_b,
  output logic            out_valid,
  output logic            out_rd_we,
  output logic [REGW-1:0] out_rd,
  output logic [XLEN-1:0] out_data,
  output logic            out_cr_we,
  output logic [CRW-1:0]  out_cr
);

  logic              rst_sn;
  mctl_t             in_ctl;
  logic [DEPTH-1:0]  vld_q;
  mctl_t [DEPTH-1:0] ctl_q;
  logic [2*XLEN-1:0] prod;
  mctl_t             last_ctl;

  mulp_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  always_comb begin
    in_ctl.rec = in_rec;
    in_ctl.rd  = in_rd;
    in_ctl.op  = mop_e'(in_op);
  end

  mulp_ctl_pipe #(.DEPTH(DEPTH)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .in_valid (in_valid),
    .in_ctl   (in_ctl),
    .vld_q    (vld_q),
    .ctl_q    (ctl_q)
  );

  mulp_core #(.XLEN(XLEN), .DEPTH(DEPTH)) u_core (
    .clk      (clk),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .stg_vld  (vld_q[DEPTH-2:0]),
    .prod     (prod)
  );

  assign last_ctl = ctl_q[DEPTH-1];

  mulp_fmt #(.XLEN(XLEN)) u_fmt (
    .prod (prod),
    .op   (last_ctl.op),
    .res  (out_data),
    .cr   (out_cr)
  );

  assign out_valid = vld_q[DEPTH-1];
  assign out_rd_we = vld_q[DEPTH-1];
  assign out_rd    = last_ctl.rd;
  assign out_cr_we = vld_q[DEPTH-1] & last_ctl.rec;

endmodule

// File: rtl/mul_pipe_chk.sv
module mul_pipe_chk #(
  parameter int DEPTH = 4,
  parameter int XLEN  = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      in_op,
  input logic [4:0]      in_rd,
  input logic            out_valid,
  input logic            out_rd_we,
  input logic [4:0]      out_rd,
  input logic [XLEN-1:0] out_data,
  input logic            out_cr_we,
  input logic [31:0]     out_cr
);

  localparam int HW = XLEN / 2;

  logic [DEPTH-1:0] sh_v;
  logic [4:0]       sh_rd [DEPTH];
  logic [1:0]       sh_op [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_v <= '0;
    end else begin
      sh_v <= {sh_v[DEPTH-2:0], in_valid};
    end
  end

  always_ff @(posedge clk) begin
    sh_rd[0] <= in_rd;
    sh_op[0] <= in_op;
    for (int k = 1; k < DEPTH; k++) begin
      sh_rd[k] <= sh_rd[k-1];
      sh_op[k] <= sh_op[k-1];
    end
  end

  // R1
  lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh_v[DEPTH-1]);

  // R3
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_cr_we);

  // R8
  rd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rd == sh_rd[DEPTH-1]) && out_rd_we);

  // R8
  we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_rd_we && !out_cr_we);

  // R9
  cr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_we |-> out_valid);

  // R10
  cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_we |-> ($countones(out_cr) == 1) && (out_cr[28:0] == '0));

  // R10
  cr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cr_we && out_data == '0) |-> out_cr == 32'h2000_0000);

  // R7
  hi32_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_op[DEPTH-1] == 2'd2) |-> out_data[XLEN-1:HW] == out_data[HW-1:0]);

endmodule

bind mul_pipe_unit mul_pipe_chk #(.DEPTH(DEPTH), .XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_rd     (in_rd),
  .out_valid (out_valid),
  .out_rd_we (out_rd_we),
  .out_rd    (out_rd),
  .out_data  (out_data),
  .out_cr_we (out_cr_we),
  .out_cr    (out_cr)
);

// File: tb/sim_mul_pipe_unit.sv
`timescale 1ns/1ps
module sim_mul_pipe_unit;

  localparam int DEPTH = 4;

  localparam int K_LO    = 0;
  localparam int K_HIS   = 1;
  localparam int K_HIU   = 2;
  localparam int K_LOW32 = 3;
  localparam int K_H32S  = 4;
  localparam int K_H32U  = 5;
  localparam int K_RSV   = 6;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [4:0]  in_rd;
  logic        in_rec;
  logic [64:0] in_a;
  logic [64:0] in_b;
  logic        out_valid;
  logic        out_rd_we;
  logic [4:0]  out_rd;
  logic [63:0] out_data;
  logic        out_cr_we;
  logic [31:0] out_cr;

  typedef struct {
    bit          v;
    logic [4:0]  rd;
    bit          rec;
    logic [63:0] data;
    logic [31:0] cr;
    int          req;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  mul_pipe_unit #(.DEPTH(DEPTH), .XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_rd(in_rd), .in_rec(in_rec), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_rd_we(out_rd_we), .out_rd(out_rd),
    .out_data(out_data), .out_cr_we(out_cr_we), .out_cr(out_cr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string req_name(int r);
    case (r)
      5:       return "R5";
      6:       return "R6";
      7:       return "R7";
      default: return "R4";
    endcase
  endfunction

  function automatic int req_of(int kind);
    case (kind)
      K_HIS:          return 5;
      K_HIU:          return 6;
      K_H32S, K_H32U: return 7;
      default:        return 4;
    endcase
  endfunction

  function automatic logic [1:0] op_of(int kind);
    case (kind)
      K_HIS, K_HIU:   return 2'd1;
      K_H32S, K_H32U: return 2'd2;
      K_RSV:          return 2'd3;
      default:        return 2'd0;
    endcase
  endfunction

  function automatic logic [64:0] widen(int kind, logic [63:0] x);
    case (kind)
      K_HIS:            return {x[63], x};
      K_LOW32, K_H32S:  return {{33{x[31]}}, x[31:0]};
      K_H32U:           return {33'd0, x[31:0]};
      default:          return {1'b0, x};
    endcase
  endfunction

  function automatic logic [63:0] ref_result(int kind, logic [63:0] ra, logic [63:0] rb);
    logic [127:0]        pu;
    logic signed [127:0] ps;
    logic [63:0]         u32;
    logic signed [63:0]  s32;
    pu  = {64'd0, ra} * {64'd0, rb};
    ps  = $signed({{64{ra[63]}}, ra}) * $signed({{64{rb[63]}}, rb});
    u32 = {32'd0, ra[31:0]} * {32'd0, rb[31:0]};
    s32 = $signed({{32{ra[31]}}, ra[31:0]}) * $signed({{32{rb[31]}}, rb[31:0]});
    case (kind)
      K_HIS:   return ps[127:64];
      K_HIU:   return pu[127:64];
      K_LOW32: return s32;
      K_H32S:  return {s32[63:32], s32[63:32]};
      K_H32U:  return {u32[63:32], u32[63:32]};
      default: return pu[63:0];
    endcase
  endfunction

  function automatic logic [31:0] ref_cr(logic [63:0] d);
    if (d[63]) return 32'h8000_0000;
    if (d == 64'd0) return 32'h2000_0000;
    return 32'h4000_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_idle();
    exp_t e;
    e.v = 0; e.rd = '0; e.rec = 0; e.data = '0; e.cr = '0; e.req = 4;
    q.push_back(e);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic beat(bit v, int kind, logic [63:0] ra, logic [63:0] rb,
                      logic [4:0] rd, bit rec);
    exp_t e;
    exp_t g;
    in_valid = v;
    in_op    = op_of(kind);
    in_rd    = rd;
    in_rec   = rec;
    in_a     = widen(kind, ra);
    in_b     = widen(kind, rb);
    e.v    = v;
    e.rd   = rd;
    e.rec  = rec;
    e.data = ref_result(kind, ra, rb);
    e.cr   = ref_cr(e.data);
    e.req  = req_of(kind);
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    g = q.pop_front();
    if (g.v) begin
      chk(out_valid === 1'b1, "R1", "valid after latency", {63'd0, out_valid}, 64'd1);
      chk(out_rd_we === 1'b1, "R8", "rd write enable", {63'd0, out_rd_we}, 64'd1);
      chk(out_rd === g.rd, "R8", "rd number", {59'd0, out_rd}, {59'd0, g.rd});
      chk(out_data === g.data, req_name(g.req), "result", out_data, g.data);
      chk(out_cr_we === g.rec, "R9", "cr write enable", {63'd0, out_cr_we}, {63'd0, g.rec});
      if (g.rec) chk(out_cr === g.cr, "R10", "cr word", {32'd0, out_cr}, {32'd0, g.cr});
    end else begin
      chk(out_valid === 1'b0, "R2", "valid on idle cycle", {63'd0, out_valid}, 64'd0);
      chk(out_rd_we === 1'b0 && out_cr_we === 1'b0, "R8", "enables on idle cycle",
          {62'd0, out_rd_we, out_cr_we}, 64'd0);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) beat(0, K_LO, 64'd0, 64'd0, 5'd0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    q.delete();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0 && out_rd_we === 1'b0 && out_cr_we === 1'b0, "R3",
          "outputs in reset", {61'd0, out_valid, out_rd_we, out_cr_we}, 64'd0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R3", "valid after release", {63'd0, out_valid}, 64'd0);
    end
    for (int i = 0; i < DEPTH - 1; i++) push_idle();
  endtask

  task automatic rand_run(int kind, int n);
    for (int i = 0; i < n; i++) begin
      logic [63:0] ra;
      logic [63:0] rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (($urandom % 4) == 0) idle(1);
      beat(1, kind, ra, rb, 5'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_rd = 5'd0;
    in_rec = 1'b0; in_a = '0; in_b = '0;
    do_reset();

    // R4 worked example, R9 record clear
    beat(1, K_LO, 64'h1000, 64'h1111, 5'd17, 0);
    idle(DEPTH);
    // R10 positive result with record set
    beat(1, K_LO, 64'h1000, 64'h1111, 5'd17, 1);
    idle(DEPTH);
    // R10 zero result
    beat(1, K_LO, 64'd0, 64'd5, 5'd3, 1);
    // R5 / R10 all-ones high half is negative
    beat(1, K_HIS, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'd4, 1);
    // R6 same operands unsigned give zero high half
    beat(1, K_HIU, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'd5, 1);
    // R7 negative high word duplicated
    beat(1, K_H32S, 64'hFFFF_FFFF, 64'd7, 5'd6, 1);
    // R4 code 3 behaves as low doubleword
    beat(1, K_RSV, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 5'd7, 1);
    // R2 back-to-back, distinct numbers
    for (int i = 0; i < 8; i++) beat(1, K_LO, 64'(i + 3), 64'(i * 11 + 1), 5'(i + 20), 0);
    idle(DEPTH);

    // R3 reset with beats in flight: they must never emerge
    beat(1, K_LO, 64'd9, 64'd9, 5'd1, 1);
    beat(1, K_LO, 64'd8, 64'd8, 5'd2, 1);
    do_reset();
    idle(DEPTH + 2);

    rand_run(K_LO, 1000);
    rand_run(K_HIS, 1000);
    rand_run(K_HIU, 1000);
    rand_run(K_LOW32, 1000);
    rand_run(K_H32S, 1000);
    rand_run(K_H32U, 1000);
    rand_run(K_RSV, 200);
    idle(DEPTH + 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule